// File: doc/BRIEF.md
# Two-Mode Standby Clock Controller

This controller parks a small processor core in one of two low-power states and brings it back. The instruction decoder raises a one-cycle halt or stop request. In the shallow state (HALT) only the CPU clock is gated. In the deep state (STOP) the CPU clock is gated and both high-speed main oscillators are switched off as well. A pending interrupt releases either state.

When the core leaves STOP while the main clock comes from the external crystal oscillator, that oscillator needs time to settle. A programmable stabilization count keeps the CPU clock gated for that many cycles after the wake-up. A wake-up from HALT, or from STOP on the internal high-speed oscillator, resumes the CPU clock on the next cycle. STOP is refused while the core runs on the subsystem clock. The subsystem oscillator is never switched off by this block.

Top module: `stby_clk_ctrl`

## Requirements
- R1: With ready_o high, no pending interrupt and halt_req_i high, the cycle after the request edge shows cpu_clk_en_o and ready_o low. hx_osc_en_o and hi_osc_en_o stay high. HALT may be entered on the main clock or on the subsystem clock.
- R2: With ready_o high, no pending interrupt, halt_req_i low, stop_req_i high and sub_clk_sel_i low (main clock), the next cycle shows cpu_clk_en_o, ready_o, hx_osc_en_o and hi_osc_en_o all low.
- R3: In HALT, an interrupt sampled at an edge brings cpu_clk_en_o and ready_o high in the cycle after that edge.
- R4: In STOP, with ext_osc_sel_i high (external crystal is the main clock) and a nonzero stabilization value N, an interrupt sampled at an edge gives the following. Both high-speed oscillator enables return high in the next cycle. cpu_clk_en_o stays low for exactly N cycles. The CPU clock gets no enabled edge during those N cycles. An interrupt held during the wait does not shorten it.
- R5: In STOP, with ext_osc_sel_i low or a stabilization value of zero, an interrupt makes ready_o high in the cycle after the edge that sampled it.
- R6: A stop request made in RUN while sub_clk_sel_i is high (subsystem clock), with no halt request and no interrupt, is ignored. The controller stays in RUN and stop_err_o is high for exactly the one cycle after the request edge.
- R7: sub_osc_en_o is high in every state, including HALT and STOP.
- R8: An interrupt pending in the same cycle as a halt or stop request wins. The controller stays in RUN and ready_o stays high.
- R9: Out of reset the controller is in RUN: cpu_clk_en_o, ready_o and both high-speed oscillator enables are high, and stop_err_o is low. cpu_clk_en_o equals ready_o at all times. stop_err_o is only ever high while ready_o is high.
- R10: The stabilization value is a CNT_W-bit register that resets to STAB_RST (default 8). A cycle with stab_load_i high writes stab_val_i into it. A wake from STOP uses the value held at the wake-up edge.
- R11: When halt_req_i and stop_req_i are both high in RUN, HALT is entered and the oscillators stay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_req_i | input | 1 | One-cycle request for the shallow standby state |
| stop_req_i | input | 1 | One-cycle request for the deep standby state |
| irq_pend_i | input | 1 | An interrupt request is pending |
| sub_clk_sel_i | input | 1 | 1: CPU runs on the subsystem clock; 0: main clock |
| ext_osc_sel_i | input | 1 | 1: main clock is the external crystal oscillator; 0: internal high-speed oscillator |
| stab_load_i | input | 1 | Write strobe for the stabilization value |
| stab_val_i | input | CNT_W | Stabilization wait length in cycles |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| hx_osc_en_o | output | 1 | External high-speed oscillator enable |
| hi_osc_en_o | output | 1 | Internal high-speed oscillator enable |
| sub_osc_en_o | output | 1 | Subsystem oscillator enable |
| ready_o | output | 1 | High only in RUN |
| stop_err_o | output | 1 | One-cycle pulse for a refused stop request |

## Verification
All outputs are decoded from a single state register, so every response to a request or an interrupt is due in the cycle that follows the edge which sampled it. The one exception is the stabilization wait, where ready_o returns exactly N cycles later. stop_err_o is registered and lasts one cycle. The bench drives inputs one nanosecond after a rising edge. It updates a behavioural model on each rising edge and compares all outputs with the model on the next falling edge. The directed checks take their samples on that same falling edge. For the wait, they count the falling edges on which ready_o is low and compare that count with N.

// File: rtl/stby_pkg.sv
package stby_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HALT = 2'd1,
      ST_STOP = 2'd2,
      ST_WAIT = 2'd3
   } stby_state_e;

endpackage

// File: rtl/stby_req_filter.sv
module stby_req_filter #(
   parameter bit HAS_SUB_OSC = 1'b1
) (
   input  logic in_run,
   input  logic halt_req,
   input  logic stop_req,
   input  logic irq_pend,
   input  logic sub_sel,
   output logic go_halt,
   output logic go_stop,
   output logic refuse
);

   logic on_sub;
   logic accept;

   generate
      if (HAS_SUB_OSC) begin : g_sub
         assign on_sub = sub_sel;
      end else begin : g_nosub
         // Without a subsystem oscillator the core is always on the main clock.
         assign on_sub = sub_sel & 1'b0;
      end
   endgenerate

   always_comb begin
      accept  = in_run & ~irq_pend;
      go_halt = accept & halt_req;
      go_stop = accept & ~halt_req & stop_req & ~on_sub;
      refuse  = accept & ~halt_req & stop_req & on_sub;
   end

endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer #(
   parameter int          CNT_W    = 16,
   parameter int unsigned STAB_RST = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             start,
   input  logic             count,
   output logic             zero,
   output logic             last
);

   localparam logic [CNT_W-1:0] RST_VAL = STAB_RST[CNT_W-1:0];
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [CNT_W-1:0] stab_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stab_q <= RST_VAL;
      end else if (load) begin
         stab_q <= load_val;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= stab_q;
      end else if (count && cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign zero = (stab_q == '0);
   assign last = (cnt_q == ONE);

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
   import stby_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        go_halt,
   input  logic        go_stop,
   input  logic        refuse,
   input  logic        irq_pend,
   input  logic        ext_sel,
   input  logic        stab_zero,
   input  logic        wait_last,
   output stby_state_e state,
   output logic        start_wait,
   output logic        counting,
   output logic        err_pulse
);

   stby_state_e state_q, state_d;
   logic        err_q;

   always_comb begin
      state_d    = state_q;
      start_wait = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (go_halt)      state_d = ST_HALT;
            else if (go_stop) state_d = ST_STOP;
         end
         ST_HALT: begin
            if (irq_pend) state_d = ST_RUN;
         end
         ST_STOP: begin
            if (irq_pend) begin
               if (ext_sel && !stab_zero) begin
                  state_d    = ST_WAIT;
                  start_wait = 1'b1;
               end else begin
                  state_d = ST_RUN;
               end
            end
         end
         ST_WAIT: begin
            if (wait_last) state_d = ST_RUN;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_RUN;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= refuse;
      end
   end

   assign state     = state_q;
   assign counting  = (state_q == ST_WAIT);
   assign err_pulse = err_q;

endmodule

// File: rtl/stby_clk_out.sv
module stby_clk_out
   import stby_pkg::*;
#(
   parameter bit HAS_SUB_OSC = 1'b1
) (
   input  stby_state_e state,
   output logic        cpu_clk_en,
   output logic        hx_osc_en,
   output logic        hi_osc_en,
   output logic        sub_osc_en,
   output logic        ready
);

   always_comb begin
      cpu_clk_en = (state == ST_RUN);
      ready      = (state == ST_RUN);
      hx_osc_en  = (state != ST_STOP);
      hi_osc_en  = (state != ST_STOP);
   end

   generate
      if (HAS_SUB_OSC) begin : g_sub_en
         assign sub_osc_en = 1'b1;
      end else begin : g_sub_off
         assign sub_osc_en = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/stby_clk_ctrl.sv
module stby_clk_ctrl
   import stby_pkg::*;
#(
   parameter int          CNT_W       = 16,
   parameter int unsigned STAB_RST    = 8,
   parameter bit          HAS_SUB_OSC = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             halt_req_i,
   input  logic             stop_req_i,
   input  logic             irq_pend_i,
   input  logic             sub_clk_sel_i,
   input  logic             ext_osc_sel_i,
   input  logic             stab_load_i,
   input  logic [CNT_W-1:0] stab_val_i,
   output logic             cpu_clk_en_o,
   output logic             hx_osc_en_o,
   output logic             hi_osc_en_o,
   output logic             sub_osc_en_o,
   output logic             ready_o,
   output logic             stop_err_o
);

   localparam longint unsigned CNT_MAX = (64'd1 << CNT_W) - 64'd1;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("stby_clk_ctrl: CNT_W must be 1..32");
      end
      if (longint'(STAB_RST) > CNT_MAX) begin : g_bad_rst
         $error("stby_clk_ctrl: STAB_RST does not fit in CNT_W bits");
      end
   endgenerate

   stby_state_e run_state;
   logic        in_run;
   logic        go_halt, go_stop, refuse;
   logic        start_wait, counting;
   logic        stab_zero, wait_last;

   assign in_run = (run_state == ST_RUN);

   stby_req_filter #(.HAS_SUB_OSC(HAS_SUB_OSC)) u_filter (
      .in_run   (in_run),
      .halt_req (halt_req_i),
      .stop_req (stop_req_i),
      .irq_pend (irq_pend_i),
      .sub_sel  (sub_clk_sel_i),
      .go_halt  (go_halt),
      .go_stop  (go_stop),
      .refuse   (refuse)
   );

   stby_stab_timer #(.CNT_W(CNT_W), .STAB_RST(STAB_RST)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load     (stab_load_i),
      .load_val (stab_val_i),
      .start    (start_wait),
      .count    (counting),
      .zero     (stab_zero),
      .last     (wait_last)
   );

   stby_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .go_halt    (go_halt),
      .go_stop    (go_stop),
      .refuse     (refuse),
      .irq_pend   (irq_pend_i),
      .ext_sel    (ext_osc_sel_i),
      .stab_zero  (stab_zero),
      .wait_last  (wait_last),
      .state      (run_state),
      .start_wait (start_wait),
      .counting   (counting),
      .err_pulse  (stop_err_o)
   );

   stby_clk_out #(.HAS_SUB_OSC(HAS_SUB_OSC)) u_out (
      .state      (run_state),
      .cpu_clk_en (cpu_clk_en_o),
      .hx_osc_en  (hx_osc_en_o),
      .hi_osc_en  (hi_osc_en_o),
      .sub_osc_en (sub_osc_en_o),
      .ready      (ready_o)
   );

endmodule

// File: rtl/stby_clk_ctrl_chk.sv
module stby_clk_ctrl_chk
   import stby_pkg::*;
#(
   parameter bit HAS_SUB_OSC = 1'b1
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        halt_req_i,
   input logic        stop_req_i,
   input logic        irq_pend_i,
   input logic        sub_clk_sel_i,
   input logic        ext_osc_sel_i,
   input stby_state_e run_state,
   input logic        cpu_clk_en_o,
   input logic        hx_osc_en_o,
   input logic        hi_osc_en_o,
   input logic        ready_o,
   input logic        stop_err_o
);

   assert_halt_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && halt_req_i && !irq_pend_i)
      |=> (!cpu_clk_en_o && hx_osc_en_o && hi_osc_en_o));

   assert_stop_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && stop_req_i && !halt_req_i && !irq_pend_i && !sub_clk_sel_i)
      |=> (!cpu_clk_en_o && !hx_osc_en_o && !hi_osc_en_o));

   assert_halt_wake_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_state == ST_HALT && irq_pend_i) |=> ready_o);

   assert_wait_osc_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_state == ST_WAIT) |-> (hx_osc_en_o && hi_osc_en_o && !cpu_clk_en_o));

   assert_stop_fast_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_state == ST_STOP && irq_pend_i && !ext_osc_sel_i) |=> ready_o);

   assert_stop_refused_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (HAS_SUB_OSC && ready_o && stop_req_i && !halt_req_i && !irq_pend_i && sub_clk_sel_i)
      |=> (ready_o && stop_err_o));

   assert_err_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_err_o |=> !stop_err_o);

   assert_irq_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && irq_pend_i) |=> ready_o);

   assert_err_in_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_err_o |-> ready_o);

endmodule

bind stby_clk_ctrl stby_clk_ctrl_chk #(.HAS_SUB_OSC(HAS_SUB_OSC)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .halt_req_i    (halt_req_i),
   .stop_req_i    (stop_req_i),
   .irq_pend_i    (irq_pend_i),
   .sub_clk_sel_i (sub_clk_sel_i),
   .ext_osc_sel_i (ext_osc_sel_i),
   .run_state     (run_state),
   .cpu_clk_en_o  (cpu_clk_en_o),
   .hx_osc_en_o   (hx_osc_en_o),
   .hi_osc_en_o   (hi_osc_en_o),
   .ready_o       (ready_o),
   .stop_err_o    (stop_err_o)
);

// File: tb/stby_clk_ctrl_tb.sv
`timescale 1ns/1ps
module stby_clk_ctrl_tb;

   localparam int CNT_W    = 16;
   localparam int STAB_DEF = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             halt = 1'b0, stop = 1'b0, irq = 1'b0;
   logic             sub_sel = 1'b0, ext_sel = 1'b0, load = 1'b0;
   logic [CNT_W-1:0] load_val = '0;
   logic             cpu_en, hx_en, hi_en, sub_en, ready, err;

   stby_clk_ctrl #(.CNT_W(CNT_W), .STAB_RST(STAB_DEF)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .halt_req_i(halt), .stop_req_i(stop),
      .irq_pend_i(irq), .sub_clk_sel_i(sub_sel), .ext_osc_sel_i(ext_sel),
      .stab_load_i(load), .stab_val_i(load_val), .cpu_clk_en_o(cpu_en),
      .hx_osc_en_o(hx_en), .hi_osc_en_o(hi_en), .sub_osc_en_o(sub_en),
      .ready_o(ready), .stop_err_o(err)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Behavioural reference: 0 run, 1 halt, 2 stop, 3 settling
   int m_mode = 0;
   int m_stab = STAB_DEF;
   int m_goal = 0;
   int m_done = 0;
   bit m_err  = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_stab = STAB_DEF; m_err = 1'b0;
      end else begin
         m_err = 1'b0;
         if (m_mode == 0) begin
            if (!irq && halt) m_mode = 1;
            else if (!irq && stop && sub_sel) m_err = 1'b1;
            else if (!irq && stop) m_mode = 2;
         end else if (m_mode == 1) begin
            if (irq) m_mode = 0;
         end else if (m_mode == 2) begin
            if (irq && ext_sel && m_stab != 0) begin
               m_mode = 3; m_goal = m_stab; m_done = 0;
            end else if (irq) m_mode = 0;
         end else begin
            m_done++;
            if (m_done == m_goal) m_mode = 0;
         end
         if (load) m_stab = int'(load_val);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9 cpu_clk_en vs model", cpu_en, m_mode == 0);
         chk("R9 ready vs model", ready, m_mode == 0);
         chk("R2 hx_osc_en vs model", hx_en, m_mode != 2);
         chk("R2 hi_osc_en vs model", hi_en, m_mode != 2);
         chk("R7 sub_osc_en vs model", sub_en, 1'b1);
         chk("R6 stop_err vs model", err, m_err);
      end
   end

   int gated_edges = 0;
   always @(posedge clk) if (cpu_en === 1'b1) gated_edges++;

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic pulse_halt();
      step(); halt = 1'b1; step(); halt = 1'b0; @(negedge clk);
   endtask

   task automatic pulse_stop();
      step(); stop = 1'b1; step(); stop = 1'b0; @(negedge clk);
   endtask

   task automatic pulse_irq();
      step(); irq = 1'b1; step(); irq = 1'b0; @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // Count falling edges with ready low, starting at the current one
   task automatic count_wait(output int n, output int edges);
      int e0;
      e0 = gated_edges;
      n = 0;
      while (ready === 1'b0 && n < 1000) begin
         n++;
         @(negedge clk);
      end
      edges = gated_edges - e0;
   endtask

   initial begin
      int n, edges;
      idle(3);
      @(negedge clk);
      chk("R9 reset cpu_clk_en", cpu_en, 1'b1);
      chk("R9 reset stop_err", err, 1'b0);
      step(); rst_n = 1'b1;
      @(negedge clk);
      chk("R9 after reset ready", ready, 1'b1);
      chk("R9 after reset hx_osc_en", hx_en, 1'b1);

      // HALT on the main clock
      pulse_halt();
      chk("R1 halt ready low", ready, 1'b0);
      chk("R1 halt cpu gated", cpu_en, 1'b0);
      chk("R1 halt hx on", hx_en, 1'b1);
      chk("R1 halt hi on", hi_en, 1'b1);
      idle(4);
      pulse_irq();
      chk("R3 halt wake next cycle", ready, 1'b1);

      // STOP with the crystal and the reset stabilization value
      ext_sel = 1'b1;
      pulse_stop();
      chk("R2 stop cpu gated", cpu_en, 1'b0);
      chk("R2 stop hx off", hx_en, 1'b0);
      chk("R2 stop hi off", hi_en, 1'b0);
      chk("R7 stop sub on", sub_en, 1'b1);
      idle(3);
      pulse_irq();
      chk("R4 hx back on", hx_en, 1'b1);
      chk("R4 hi back on", hi_en, 1'b1);
      count_wait(n, edges);
      chk_int("R10 wait length with reset value", n, STAB_DEF);
      chk_int("R4 no cpu edges during wait", edges, 0);

      // Load 5 and hold the interrupt through the wait
      step(); load = 1'b1; load_val = 16'd5; step(); load = 1'b0;
      pulse_stop();
      step(); irq = 1'b1; step();
      @(negedge clk);
      count_wait(n, edges);
      chk_int("R4 wait with held interrupt", n, 5);
      chk_int("R4 no cpu edges during wait", edges, 0);
      step(); irq = 1'b0;

      // Internal oscillator: no wait
      ext_sel = 1'b0;
      pulse_stop();
      chk("R2 stop internal osc off", hi_en, 1'b0);
      pulse_irq();
      chk("R5 internal osc wake next cycle", ready, 1'b1);

      // Crystal with a zero value: no wait
      ext_sel = 1'b1;
      step(); load = 1'b1; load_val = 16'd0; step(); load = 1'b0;
      pulse_stop();
      pulse_irq();
      chk("R5 zero value wake next cycle", ready, 1'b1);

      // STOP refused on the subsystem clock
      sub_sel = 1'b1;
      pulse_stop();
      chk("R6 refused stays in run", ready, 1'b1);
      chk("R6 refused hx on", hx_en, 1'b1);
      chk("R6 error pulse", err, 1'b1);
      @(negedge clk);
      chk("R6 error one cycle", err, 1'b0);

      // HALT allowed on the subsystem clock
      pulse_halt();
      chk("R1 halt on subsystem clock", ready, 1'b0);
      chk("R7 halt sub on", sub_en, 1'b1);
      pulse_irq();
      chk("R3 wake from subsystem halt", ready, 1'b1);
      sub_sel = 1'b0;

      // Interrupt coincident with requests
      step(); irq = 1'b1; halt = 1'b1; step(); irq = 1'b0; halt = 1'b0;
      @(negedge clk);
      chk("R8 irq beats halt", ready, 1'b1);
      step(); irq = 1'b1; stop = 1'b1; step(); irq = 1'b0; stop = 1'b0;
      @(negedge clk);
      chk("R8 irq beats stop", ready, 1'b1);
      chk("R8 oscillators on", hx_en, 1'b1);

      // Both requests together
      step(); halt = 1'b1; stop = 1'b1; step(); halt = 1'b0; stop = 1'b0;
      @(negedge clk);
      chk("R11 both requests enter halt", ready, 1'b0);
      chk("R11 both requests oscillators on", hx_en, 1'b1);
      pulse_irq();
      chk("R3 wake after combined request", ready, 1'b1);

      idle(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule